// File: doc/BRIEF.md
# Debug Command Handler with Guard Time

This block sits behind a single-wire debug framing layer and executes the short control commands that layer delivers. Each command is an opcode byte and one data byte. It is presented on a valid/ready stream. Three opcodes are recognised. One controls a CPU halt line. One writes a bank of per-domain reset lines. One picks how long the block waits before it answers.

Every accepted command produces exactly one response byte, either ACK or NACK. The response is held back by a guard delay. That delay is measured in bit periods, counted on a bit-period tick input, from the moment the command is accepted. This gives the master time to turn the line around before the block starts transmitting.

Both edges are streams. `cmd_ready` is high only while no response is outstanding. A command offered while `cmd_ready` is low is not taken, and it has no effect on the block. `rsp_valid`, once raised, stays high with `rsp_data` unchanged until the cycle in which `rsp_ready` is also high. The block accepts the next command only after that handshake.

Top module: `dbg_cmd_guard`

## Requirements
- R1: After reset, `halt_o` is 0, all bits of `rst_dom_o` are 0, `rsp_valid` is 0, `cmd_ready` is 1, and the guard setting is 128 bit periods.
- R2: Opcode 0x82 with data 0x01 sets `halt_o` to 1, and with data 0x00 clears it. Both get the ACK byte 0x40. The output changes at the clock edge that accepts the command.
- R3: Opcode 0x82 with any data other than 0x00 or 0x01 gets the NACK byte 0x41 and leaves `halt_o` unchanged.
- R4: Opcode 0x83 writes data bit i to `rst_dom_o[i]` for every i below NDOM, and gets ACK 0x40. Data bits at NDOM and above are ignored.
- R5: Opcode 0x84 with data 0x00, 0x01, 0x02 or 0x03 selects a guard of 128, 16, 4 or 1 bit periods and gets ACK 0x40. The new guard applies from the next accepted command onward. The command's own response still uses the previous guard.
- R6: Opcode 0x84 with data above 0x03 gets NACK 0x41 and leaves the guard setting unchanged.
- R7: Any opcode other than 0x82, 0x83 or 0x84 gets NACK 0x41 and changes neither `halt_o`, `rst_dom_o` nor the guard setting.
- R8: Let G be the guard in effect. `rsp_valid` rises in the cycle after the G-th cycle with `bit_tick` high that follows the accepting edge. A tick in the accepting cycle itself does not count.
- R9: `cmd_ready` is 0 from the accepting edge until the response handshake. A command offered meanwhile has no effect and yields no response.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold. `cmd_ready` returns to 1 in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_opcode | input | 8 | Command opcode |
| cmd_data | input | 8 | Command data byte |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| halt_o | output | 1 | CPU halt request |
| rst_dom_o | output | NDOM | Per-domain reset requests |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Response byte (0x40 ACK, 0x41 NACK) |

## Verification
The hardest case to reach is the guard setting's effect. It is invisible at the ports until a later command's response. It also has to be told apart from the delay applied to the command that changed it. The stimulus therefore follows each guard write, valid or rejected, with another command. For each response, the scoreboard counts the ticks between acceptance and `rsp_valid` against the guard it expects.

Commands offered while busy are driven during a long 16-period guard, so the offer falls inside the waiting window. A stalled `rsp_ready` pattern keeps responses pending over many cycles to exercise the hold rule.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam logic [7:0] OP_HALT  = 8'h82;
  localparam logic [7:0] OP_RST   = 8'h83;
  localparam logic [7:0] OP_GUARD = 8'h84;
  localparam logic [7:0] RSP_ACK  = 8'h40;
  localparam logic [7:0] RSP_NACK = 8'h41;

  typedef enum logic [1:0] {
    GSEL_LONG  = 2'd0,
    GSEL_MED   = 2'd1,
    GSEL_SHORT = 2'd2,
    GSEL_MIN   = 2'd3
  } gsel_e;

  typedef struct packed {
    logic  halt_wr;
    logic  halt_val;
    logic  dom_wr;
    logic  guard_wr;
    gsel_e guard_val;
    logic  ack;
  } cmd_act_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } rsp_st_e;
endpackage

// File: rtl/dbgc_decode.sv
module dbgc_decode
  import dbgc_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] data,
  output cmd_act_t   act
);
  always_comb begin
    act = '0;
    act.guard_val = GSEL_LONG;
    unique case (opcode)
      OP_HALT: begin
        if (data == 8'h00 || data == 8'h01) begin
          act.halt_wr  = 1'b1;
          act.halt_val = data[0];
          act.ack      = 1'b1;
        end
      end
      OP_RST: begin
        act.dom_wr = 1'b1;
        act.ack    = 1'b1;
      end
      OP_GUARD: begin
        if (data[7:2] == 6'd0) begin
          act.guard_wr  = 1'b1;
          act.guard_val = gsel_e'(data[1:0]);
          act.ack       = 1'b1;
        end
      end
      default: act = act;
    endcase
  end
endmodule

// File: rtl/dbgc_ctrl_regs.sv
module dbgc_ctrl_regs
  import dbgc_pkg::*;
#(
  parameter int NDOM = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  cmd_act_t        act,
  input  logic [NDOM-1:0] dom_bits,
  output logic            halt_o,
  output logic [NDOM-1:0] rst_dom_o,
  output gsel_e           gsel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_o <= 1'b0;
      gsel   <= GSEL_LONG;
    end else if (accept) begin
      if (act.halt_wr)  halt_o <= act.halt_val;
      if (act.guard_wr) gsel   <= act.guard_val;
    end
  end

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rst_n)                    rst_dom_o[i] <= 1'b0;
      else if (accept && act.dom_wr) rst_dom_o[i] <= dom_bits[i];
    end
  end
endmodule

// File: rtl/dbgc_guard_timer.sv
module dbgc_guard_timer
  import dbgc_pkg::*;
#(
  parameter int GLEN0 = 128,
  parameter int GLEN1 = 16,
  parameter int GLEN2 = 4,
  parameter int GLEN3 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  gsel_e      gsel,
  input  logic       ack,
  input  logic       bit_tick,
  input  logic       rsp_ready,
  output logic       cmd_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data
);
  localparam int GMAX01 = (GLEN0 > GLEN1) ? GLEN0 : GLEN1;
  localparam int GMAX23 = (GLEN2 > GLEN3) ? GLEN2 : GLEN3;
  localparam int GMAX   = (GMAX01 > GMAX23) ? GMAX01 : GMAX23;
  localparam int CW     = $clog2(GMAX + 1);

  rsp_st_e       st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] glen;

  always_comb begin
    unique case (gsel)
      GSEL_LONG:  glen = CW'(GLEN0);
      GSEL_MED:   glen = CW'(GLEN1);
      GSEL_SHORT: glen = CW'(GLEN2);
      default:    glen = CW'(GLEN3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rsp_data <= RSP_NACK;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cnt      <= glen;
          rsp_data <= ack ? RSP_ACK : RSP_NACK;
          st       <= ST_WAIT;
        end
        ST_WAIT: if (bit_tick) begin
          if (cnt == CW'(1)) st  <= ST_RESP;
          else               cnt <= cnt - CW'(1);
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
endmodule

// File: rtl/dbg_cmd_guard.sv
module dbg_cmd_guard
  import dbgc_pkg::*;
#(
  parameter int NDOM  = 6,
  parameter int GLEN0 = 128,
  parameter int GLEN1 = 16,
  parameter int GLEN2 = 4,
  parameter int GLEN3 = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [7:0]      cmd_opcode,
  input  logic [7:0]      cmd_data,
  input  logic            bit_tick,
  output logic            halt_o,
  output logic [NDOM-1:0] rst_dom_o,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [7:0]      rsp_data
);
  cmd_act_t act;
  gsel_e    gsel;
  logic     accept;

  assign accept = cmd_valid && cmd_ready;

  dbgc_decode u_dec (
    .opcode (cmd_opcode),
    .data   (cmd_data),
    .act    (act)
  );

  dbgc_ctrl_regs #(.NDOM(NDOM)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .act       (act),
    .dom_bits  (cmd_data[NDOM-1:0]),
    .halt_o    (halt_o),
    .rst_dom_o (rst_dom_o),
    .gsel      (gsel)
  );

  dbgc_guard_timer #(
    .GLEN0(GLEN0), .GLEN1(GLEN1), .GLEN2(GLEN2), .GLEN3(GLEN3)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .gsel      (gsel),
    .ack       (act.ack),
    .bit_tick  (bit_tick),
    .rsp_ready (rsp_ready),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/dbgc_chk.sv
module dbgc_chk #(
  parameter int NDOM = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            bit_tick,
  input logic            halt_o,
  input logic [NDOM-1:0] rst_dom_o,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [7:0]      rsp_data
);
  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R2
  rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == 8'h40 || rsp_data == 8'h41));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(halt_o));

  // R4
  dom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(rst_dom_o));

  // R8
  tick_before_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bit_tick));
endmodule

bind dbg_cmd_guard dbgc_chk #(.NDOM(NDOM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .bit_tick  (bit_tick),
  .halt_o    (halt_o),
  .rst_dom_o (rst_dom_o),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/sim_dbg_cmd_guard.sv
module sim_dbg_cmd_guard;
  localparam int ND = 6;

  typedef struct {
    logic [7:0] b;
    int         g;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_opcode = 8'h00;
  logic [7:0]    cmd_data = 8'h00;
  logic          bit_tick = 1'b0;
  logic          halt_o;
  logic [ND-1:0] rst_dom_o;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q[$];
  logic m_halt = 1'b0;
  logic [ND-1:0] m_dom = '0;
  int   m_g = 128;
  bit   stall_en = 1'b0;
  bit   armed = 1'b0;
  bit   seen = 1'b0;
  int   ticks = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  dbg_cmd_guard #(.NDOM(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_data(cmd_data), .bit_tick(bit_tick),
    .halt_o(halt_o), .rst_dom_o(rst_dom_o), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // tick every second cycle, response ready pattern, cycle count
  always @(posedge clk) begin
    #1;
    cyc++;
    bit_tick  = (cyc % 2 == 1);
    rsp_ready = stall_en ? (cyc % 5 == 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 stray response", rsp_data, 0);
        end else begin
          if (!seen) begin
            seen = 1'b1;
            check(ticks == q[0].g, "R8 R5 guard ticks", ticks, q[0].g);
          end
          check(rsp_data == q[0].b, "R10 R2 response byte", rsp_data, q[0].b);
          if (rsp_ready) begin
            void'(q.pop_front());
            armed = 1'b0;
            seen  = 1'b0;
          end
        end
      end else if (armed) begin
        if (ticks > q[0].g) begin
          check(1'b0, "R8 response late", ticks, q[0].g);
          armed = 1'b0;
        end
        if (bit_tick) ticks++;
      end
      if (cmd_valid && cmd_ready) begin
        armed = 1'b1;
        ticks = 0;
      end
    end
  end

  task automatic send_cmd(input logic [7:0] op, input logic [7:0] d, input string req);
    exp_t e;
    @(posedge clk); #1;
    while (!cmd_ready) begin @(posedge clk); #1; end
    cmd_valid  = 1'b1;
    cmd_opcode = op;
    cmd_data   = d;
    e.g = m_g;
    e.b = 8'h41;
    if (op == 8'h82 && d <= 8'h01) begin m_halt = d[0]; e.b = 8'h40; end
    else if (op == 8'h83) begin m_dom = d[ND-1:0]; e.b = 8'h40; end
    else if (op == 8'h84 && d <= 8'h03) begin
      e.b = 8'h40;
      m_g = (d == 8'h00) ? 128 : (d == 8'h01) ? 16 : (d == 8'h02) ? 4 : 1;
    end
    q.push_back(e);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check(halt_o == m_halt, req, halt_o, m_halt);
    check(rst_dom_o == m_dom, req, rst_dom_o, m_dom);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(halt_o == 1'b0, "R1 halt", halt_o, 0);
    check(rst_dom_o == '0, "R1 domains", rst_dom_o, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);

    send_cmd(8'h82, 8'h01, "R2 halt set, R1 default guard");
    send_cmd(8'h84, 8'h03, "R5 guard 1");
    send_cmd(8'h82, 8'h00, "R2 halt clear");
    send_cmd(8'h82, 8'h05, "R3 bad halt data");
    send_cmd(8'h82, 8'h01, "R2 halt set");
    send_cmd(8'h82, 8'h07, "R3 bad halt data keeps 1");
    send_cmd(8'h83, 8'hFF, "R4 all domains");
    send_cmd(8'h83, 8'h95, "R4 upper bits ignored");
    send_cmd(8'h84, 8'h02, "R5 guard 4");
    send_cmd(8'h84, 8'h09, "R6 bad guard");
    send_cmd(8'h82, 8'h00, "R6 guard still 4");
    send_cmd(8'h10, 8'h01, "R7 unknown opcode");
    send_cmd(8'h85, 8'h00, "R7 unknown opcode");
    send_cmd(8'h84, 8'h01, "R5 guard 16");

    // R9: offer a command while busy
    send_cmd(8'h83, 8'h2A, "R4 domains pattern");
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_opcode = 8'h83; cmd_data = 8'h00;
    for (int i = 0; i < 8 && !cmd_ready; i++) begin @(posedge clk); #1; end
    cmd_valid = 1'b0;
    wait_idle();
    check(rst_dom_o == m_dom, "R9 busy offer ignored", rst_dom_o, m_dom);
    check(halt_o == m_halt, "R9 busy offer ignored", halt_o, m_halt);

    // R10: back-pressure on the response
    stall_en = 1'b1;
    send_cmd(8'h84, 8'h03, "R10 stalled guard 1");
    send_cmd(8'h82, 8'h01, "R10 stalled halt");
    send_cmd(8'h83, 8'h01, "R10 stalled reset");
    send_cmd(8'h84, 8'h00, "R5 guard back to 128");
    stall_en = 1'b0;
    send_cmd(8'h82, 8'h00, "R5 guard 128 in effect");
    wait_idle();
    check(q.size() == 0, "R9 no pending responses", q.size(), 0);
    check(cmd_ready == 1'b1, "R10 ready after handshake", cmd_ready, 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule